// File: doc/BRIEF.md
# Load Data Extractor and Store Lane Steering Unit

This block sits between a 32-bit little-endian memory port and the register write-back path of a small processor core. For each request it forms the effective address from a base register and a signed 16-bit offset. For a load it picks the addressed byte, halfword or word out of the fetched memory word and extends it to 32 bits, with or without sign. For a store it places the source data on the byte lanes that the address selects and raises only the matching byte enables.

The address is combinational and is used by the memory in the same cycle. The memory read data is also presented in that cycle. The load result, the store lanes and a misalignment flag are registered and appear one clock later. A word access that is not on a 4-byte boundary, or a halfword access on an odd address, is flagged. Such an access is not carried out: no write-back and no byte enables are produced.

The access kind uses a 3-bit code: 0 = word, 1 = signed halfword, 2 = unsigned halfword, 3 = signed byte, 4 = unsigned byte. Codes 5 to 7 behave as a word access. For stores, codes 1 and 2 both mean halfword, and codes 3 and 4 both mean byte.

Top module: `load_align_unit`

## Requirements
- R1: `mem_addr` equals `base_addr` plus `offset` sign-extended from bit 15 to 32 bits, combinationally in the request cycle.
- R2: An aligned word load (kind 0) sets `wb_valid` on the cycle after the request and returns `mem_rdata` unchanged on `wb_data`.
- R3: A signed halfword load (kind 1) takes bits 15:0 when address bit 1 is 0 and bits 31:16 when it is 1, then fills bits 31:16 of `wb_data` with bit 15 of the selected halfword.
- R4: An unsigned halfword load (kind 2) selects its lane as in R3 and fills bits 31:16 of `wb_data` with zeros.
- R5: A signed byte load (kind 3) takes the byte at bits 8k+7:8k, where k is address bits 1:0 (little-endian: offset +0 is bits 7:0), and fills bits 31:8 with bit 7 of that byte.
- R6: An unsigned byte load (kind 4) selects its lane as in R5 and fills bits 31:8 with zeros.
- R7: An aligned word store sets `st_be` to 4'b1111 and `st_wdata` to `store_src` on the cycle after the request.
- R8: A halfword store copies `store_src[15:0]` into both halves of `st_wdata` and sets `st_be` to 4'b0011 when address bit 1 is 0, or to 4'b1100 when it is 1.
- R9: A byte store copies `store_src[7:0]` into all four lanes of `st_wdata` and sets only bit k of `st_be`, where k is address bits 1:0.
- R10: A word access with address bits 1:0 not 00, or a halfword access with address bit 0 set, sets `misalign` on the next cycle and holds `wb_valid` at 0 and `st_be` at 0.
- R11: During reset, and on the cycle after any cycle in which `req_valid` is low, `wb_valid`, `st_be`, `misalign` and `wb_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_kind | input | 3 | Access kind code (0 word, 1 half signed, 2 half unsigned, 3 byte signed, 4 byte unsigned) |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed address offset |
| store_src | input | 32 | Store source register value |
| mem_rdata | input | 32 | Memory word read at the aligned address, same cycle |
| mem_addr | output | 32 | Effective address (combinational) |
| wb_valid | output | 1 | Load result valid |
| wb_data | output | 32 | Extended load result |
| st_be | output | 4 | Store byte enables, one per lane |
| st_wdata | output | 32 | Lane-steered store data |
| misalign | output | 1 | Previous request was misaligned |

## Verification
The effective address is combinational, so the bench samples `mem_addr` a short delay after it drives the request, still inside the request cycle. The load result, byte enables, steered data and the misalign flag each pass through one register. The bench drives a request on a falling edge and compares these outputs at the next falling edge, after exactly one rising edge. Random requests over every kind, both directions and all address offsets are mixed with directed sign-boundary and misaligned cases, and each is compared against values from bench functions.

// File: rtl/lsu_pkg.sv
// Shared types for the load/store lane unit.
// Assumes a little-endian memory: byte lane k is bits 8k+7:8k of the word.
package lsu_pkg;

    typedef enum logic [2:0] {
        KIND_WORD   = 3'd0,
        KIND_HALF_S = 3'd1,
        KIND_HALF_U = 3'd2,
        KIND_BYTE_S = 3'd3,
        KIND_BYTE_U = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        SZ_WORD = 2'd0,
        SZ_HALF = 2'd1,
        SZ_BYTE = 2'd2
    } size_e;

    // Access width for a kind code; unlisted codes act as word.
    function automatic size_e size_of(input logic [2:0] kind);
        case (kind)
            KIND_HALF_S, KIND_HALF_U: size_of = SZ_HALF;
            KIND_BYTE_S, KIND_BYTE_U: size_of = SZ_BYTE;
            default:                  size_of = SZ_WORD;
        endcase
    endfunction

    // True when the kind asks for sign extension.
    function automatic logic is_signed_kind(input logic [2:0] kind);
        is_signed_kind = (kind == KIND_HALF_S) || (kind == KIND_BYTE_S);
    endfunction

endpackage

// File: rtl/lsu_agen.sv
// Effective address generator: base plus sign-extended offset.
// Assumes OFF_W <= ADDR_W. Purely combinational.
module lsu_agen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] addr
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;

    // Widen the offset by copying its top bit.
    always_comb off_ext = {{EXT_W{off[OFF_W-1]}}, off};

    // Add the widened offset to the base.
    always_comb addr = base + off_ext;
endmodule

// File: rtl/lsu_load_extract.sv
// Load extractor: picks a byte, halfword or word lane from the fetched
// word by the low address bits, then sign- or zero-extends it.
// Assumes DATA_W is a power-of-two multiple of 16. Combinational.
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]             rdata,
    input  logic [$clog2(DATA_W/8)-1:0]   lane_addr,
    input  logic [2:0]                    kind,
    output logic [DATA_W-1:0]             data
);
    localparam int LANES   = DATA_W / 8;
    localparam int HALVES  = DATA_W / 16;
    localparam int IDX_W   = $clog2(LANES);

    logic [7:0]  byte_lane [LANES];
    logic [15:0] half_lane [HALVES];

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_bytes
            assign byte_lane[gi] = rdata[8*gi +: 8];
        end
        for (gi = 0; gi < HALVES; gi++) begin : g_halves
            assign half_lane[gi] = rdata[16*gi +: 16];
        end
    endgenerate

    logic [7:0]  byte_sel;
    logic [15:0] half_sel;
    logic        sgn;

    // Choose the addressed byte and halfword lanes.
    always_comb begin
        byte_sel = byte_lane[lane_addr];
        half_sel = half_lane[lane_addr[IDX_W-1:1]];
    end

    // Extend the selection to the full data width.
    always_comb begin
        sgn = is_signed_kind(kind);
        case (size_of(kind))
            SZ_HALF: data = {{(DATA_W-16){sgn & half_sel[15]}}, half_sel};
            SZ_BYTE: data = {{(DATA_W-8){sgn & byte_sel[7]}}, byte_sel};
            default: data = rdata;
        endcase
    end
endmodule

// File: rtl/lsu_store_steer.sv
// Store lane steering: copies the source byte or halfword onto every
// lane and enables only the lanes the address selects.
// Assumes DATA_W is a power-of-two multiple of 16. Combinational.
module lsu_store_steer
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]             src,
    input  logic [$clog2(DATA_W/8)-1:0]   lane_addr,
    input  lsu_pkg::size_e                size,
    output logic [DATA_W/8-1:0]           be,
    output logic [DATA_W-1:0]             wdata
);
    localparam int LANES = DATA_W / 8;
    localparam int IDX_W = $clog2(LANES);

    genvar gl;
    generate
        for (gl = 0; gl < LANES; gl++) begin : g_lane
            localparam logic [IDX_W-1:0] LANE_ID = IDX_W'(gl);

            // Data placed on this lane for each access width.
            always_comb begin
                case (size)
                    SZ_HALF: wdata[8*gl +: 8] = src[8*(gl % 2) +: 8];
                    SZ_BYTE: wdata[8*gl +: 8] = src[7:0];
                    default: wdata[8*gl +: 8] = src[8*gl +: 8];
                endcase
            end

            // Enable this lane when the address covers it.
            always_comb begin
                case (size)
                    SZ_HALF: be[gl] = (LANE_ID[IDX_W-1:1] == lane_addr[IDX_W-1:1]);
                    SZ_BYTE: be[gl] = (LANE_ID == lane_addr);
                    default: be[gl] = 1'b1;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/lsu_align_check.sv
// Alignment checker: flags word accesses off a full-word boundary and
// halfword accesses on odd addresses. Combinational.
module lsu_align_check
    import lsu_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic [IDX_W-1:0] lane_addr,
    input  lsu_pkg::size_e   size,
    output logic             bad
);
    // Compare low address bits against the access width.
    always_comb begin
        case (size)
            SZ_HALF: bad = lane_addr[0];
            SZ_BYTE: bad = 1'b0;
            default: bad = |lane_addr;
        endcase
    end
endmodule

// File: rtl/load_align_unit.sv
// Load/store lane unit top. Forms the effective address combinationally,
// then registers the extended load result, the store lanes and the
// misalign flag one cycle after the request.
// Assumes mem_rdata holds the aligned word for mem_addr in the request
// cycle. Synchronous active-low reset.
module load_align_unit
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_is_store,
    input  logic [2:0]           req_kind,
    input  logic [DATA_W-1:0]    base_addr,
    input  logic [OFF_W-1:0]     offset,
    input  logic [DATA_W-1:0]    store_src,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic [DATA_W-1:0]    mem_addr,
    output logic                 wb_valid,
    output logic [DATA_W-1:0]    wb_data,
    output logic [DATA_W/8-1:0]  st_be,
    output logic [DATA_W-1:0]    st_wdata,
    output logic                 misalign
);
    localparam int LANES = DATA_W / 8;
    localparam int IDX_W = $clog2(LANES);

    logic [IDX_W-1:0]  lane_addr;
    size_e             size;
    logic [DATA_W-1:0] ld_data;
    logic [LANES-1:0]  be_raw;
    logic [DATA_W-1:0] wdata_raw;
    logic              bad_align;

    lsu_agen #(.ADDR_W(DATA_W), .OFF_W(OFF_W)) u_agen (
        .base (base_addr),
        .off  (offset),
        .addr (mem_addr)
    );

    // Low address bits and access width for this request.
    always_comb begin
        lane_addr = mem_addr[IDX_W-1:0];
        size      = size_of(req_kind);
    end

    lsu_load_extract #(.DATA_W(DATA_W)) u_extract (
        .rdata     (mem_rdata),
        .lane_addr (lane_addr),
        .kind      (req_kind),
        .data      (ld_data)
    );

    lsu_store_steer #(.DATA_W(DATA_W)) u_steer (
        .src       (store_src),
        .lane_addr (lane_addr),
        .size      (size),
        .be        (be_raw),
        .wdata     (wdata_raw)
    );

    lsu_align_check #(.IDX_W(IDX_W)) u_align (
        .lane_addr (lane_addr),
        .size      (size),
        .bad       (bad_align)
    );

    logic go_load;
    logic go_store;

    // Qualify the request by direction and alignment.
    always_comb begin
        go_load  = req_valid && !req_is_store && !bad_align;
        go_store = req_valid &&  req_is_store && !bad_align;
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_data  <= '0;
            st_be    <= '0;
            st_wdata <= '0;
            misalign <= 1'b0;
        end else begin
            wb_valid <= go_load;
            wb_data  <= go_load ? ld_data : '0;
            st_be    <= go_store ? be_raw : '0;
            st_wdata <= wdata_raw;
            misalign <= req_valid && bad_align;
        end
    end
endmodule

// File: rtl/load_align_unit_checks.sv
// Property checker for load_align_unit, bound to every instance.
module load_align_unit_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_is_store,
    input logic [2:0]  req_kind,
    input logic [31:0] base_addr,
    input logic [15:0] offset,
    input logic [31:0] mem_rdata,
    input logic [31:0] mem_addr,
    input logic        wb_valid,
    input logic [31:0] wb_data,
    input logic [3:0]  st_be,
    input logic [31:0] st_wdata,
    input logic        misalign
);
    // R1: zero offset leaves the base unchanged.
    always_comb begin
        if (rst_n && offset == 16'h0)
            assert (mem_addr == base_addr) else $error("p_zero_off_r1");
    end

    p_word_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_store && req_kind == 3'd0 && mem_addr[1:0] == 2'b00)
        |=> (wb_valid && wb_data == $past(mem_rdata)));

    p_byte_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_store && req_kind == 3'd3)
        |=> (wb_valid && wb_data[31:8] == {24{wb_data[7]}}));

    p_byte_zext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_store && req_kind == 3'd4)
        |=> (wb_valid && wb_data[31:8] == 24'h0));

    p_half_repl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_be == 4'b0011 || st_be == 4'b1100) |-> (st_wdata[15:0] == st_wdata[31:16]));

    p_be_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_be != 4'b0) |-> ($countones(st_be) == 1 || st_be == 4'b0011 ||
                             st_be == 4'b1100 || st_be == 4'b1111));

    p_suppress_r10: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!wb_valid && st_be == 4'b0));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!wb_valid && st_be == 4'b0 && !misalign && wb_data == 32'h0));

    p_one_dir_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid && st_be != 4'b0));
endmodule

bind load_align_unit load_align_unit_checks u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_is_store (req_is_store),
    .req_kind     (req_kind),
    .base_addr    (base_addr),
    .offset       (offset),
    .mem_rdata    (mem_rdata),
    .mem_addr     (mem_addr),
    .wb_valid     (wb_valid),
    .wb_data      (wb_data),
    .st_be        (st_be),
    .st_wdata     (st_wdata),
    .misalign     (misalign)
);

// File: tb/load_align_unit_test.sv
`timescale 1ns/1ps
module load_align_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_is_store;
    logic [2:0]  req_kind;
    logic [31:0] base_addr;
    logic [15:0] offset;
    logic [31:0] store_src;
    logic [31:0] mem_rdata;
    logic [31:0] mem_addr;
    logic        wb_valid;
    logic [31:0] wb_data;
    logic [3:0]  st_be;
    logic [31:0] st_wdata;
    logic        misalign;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    load_align_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_store(req_is_store),
        .req_kind(req_kind), .base_addr(base_addr), .offset(offset),
        .store_src(store_src), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .wb_valid(wb_valid), .wb_data(wb_data), .st_be(st_be),
        .st_wdata(st_wdata), .misalign(misalign)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bench model: is the access misaligned (R10).
    function automatic bit ref_bad(input logic [2:0] k, input logic [1:0] a);
        if (k == 3'd1 || k == 3'd2) return a[0];
        if (k == 3'd3 || k == 3'd4) return 1'b0;
        return a != 2'b00;
    endfunction

    // Bench model of load results (R2-R6).
    function automatic logic [31:0] ref_load(input logic [2:0] k, input logic [1:0] a,
                                             input logic [31:0] w);
        logic [15:0] h;
        logic [7:0]  b;
        h = a[1] ? w[31:16] : w[15:0];
        b = w >> (8 * a);
        case (k)
            3'd1: return {{16{h[15]}}, h};
            3'd2: return {16'h0, h};
            3'd3: return {{24{b[7]}}, b};
            3'd4: return {24'h0, b};
            default: return w;
        endcase
    endfunction

    // Bench model of store enables (R7-R9).
    function automatic logic [3:0] ref_be(input logic [2:0] k, input logic [1:0] a);
        if (k == 3'd1 || k == 3'd2) return a[1] ? 4'b1100 : 4'b0011;
        if (k == 3'd3 || k == 3'd4) return 4'b0001 << a;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] ref_wdata(input logic [2:0] k, input logic [31:0] s);
        if (k == 3'd1 || k == 3'd2) return {s[15:0], s[15:0]};
        if (k == 3'd3 || k == 3'd4) return {4{s[7:0]}};
        return s;
    endfunction

    function automatic string tag_of(input bit st, input logic [2:0] k);
        if (st) return (k == 3'd1 || k == 3'd2) ? "R8" : (k == 3'd3 || k == 3'd4) ? "R9" : "R7";
        case (k)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R2";
        endcase
    endfunction

    // Drive one request at a falling edge, check address now, results one edge later.
    task automatic do_req(input bit st, input logic [2:0] k, input logic [31:0] base,
                          input logic [15:0] off, input logic [31:0] src, input logic [31:0] rd);
        logic [31:0] ea;
        bit          mis;
        string       tg;
        req_valid = 1'b1; req_is_store = st; req_kind = k;
        base_addr = base; offset = off; store_src = src; mem_rdata = rd;
        ea  = base + {{16{off[15]}}, off};
        mis = ref_bad(k, ea[1:0]);
        tg  = tag_of(st, k);
        #1;
        check("R1 addr", {32'h0, mem_addr}, {32'h0, ea});
        @(negedge clk);
        req_valid = 1'b0;
        if (mis) begin
            check("R10 misalign", {63'h0, misalign}, 64'h1);
            check("R10 wb_valid", {63'h0, wb_valid}, 64'h0);
            check("R10 st_be", {60'h0, st_be}, 64'h0);
        end else if (st) begin
            check({tg, " st_be"}, {60'h0, st_be}, {60'h0, ref_be(k, ea[1:0])});
            check({tg, " st_wdata"}, {32'h0, st_wdata}, {32'h0, ref_wdata(k, src)});
            check({tg, " no wb"}, {63'h0, wb_valid}, 64'h0);
        end else begin
            check({tg, " wb_valid"}, {63'h0, wb_valid}, 64'h1);
            check({tg, " wb_data"}, {32'h0, wb_data}, {32'h0, ref_load(k, ea[1:0], rd)});
            check({tg, " no be"}, {60'h0, st_be}, 64'h0);
        end
    endtask

    task automatic idle_check();
        req_valid = 1'b0;
        @(negedge clk);
        check("R11 idle wb_valid", {63'h0, wb_valid}, 64'h0);
        check("R11 idle st_be", {60'h0, st_be}, 64'h0);
        check("R11 idle misalign", {63'h0, misalign}, 64'h0);
        check("R11 idle wb_data", {32'h0, wb_data}, 64'h0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        rst_n = 1'b0; req_valid = 1'b0; req_is_store = 1'b0; req_kind = 3'd0;
        base_addr = '0; offset = '0; store_src = '0; mem_rdata = '0;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R11: reset state.
        check("R11 reset wb_valid", {63'h0, wb_valid}, 64'h0);
        check("R11 reset st_be", {60'h0, st_be}, 64'h0);
        check("R11 reset misalign", {63'h0, misalign}, 64'h0);
        rst_n = 1'b1;
        idle_check();

        // Directed little-endian lane and extension cases (R2-R6).
        do_req(1'b0, 3'd0, 32'h0020_0004, 16'h0, 32'h0, 32'h1122_3344);
        do_req(1'b0, 3'd3, 32'h0020_0004, 16'h0, 32'h0, 32'h1122_3344);
        do_req(1'b0, 3'd4, 32'h0020_0004, 16'h3, 32'h0, 32'h1122_3344);
        do_req(1'b0, 3'd3, 32'h0020_0000, 16'h1, 32'h0, 32'h0000_8000);
        do_req(1'b0, 3'd4, 32'h0020_0000, 16'h1, 32'h0, 32'h0000_8000);
        do_req(1'b0, 3'd1, 32'h0020_0000, 16'h2, 32'h0, 32'h8001_7FFF);
        do_req(1'b0, 3'd2, 32'h0020_0000, 16'h2, 32'h0, 32'h8001_7FFF);
        do_req(1'b0, 3'd1, 32'h0020_0000, 16'h0, 32'h0, 32'h8001_7FFF);
        // R1: negative offset crossing back into previous word.
        do_req(1'b0, 3'd0, 32'h0020_0008, 16'hFFFC, 32'h0, 32'h5566_7788);
        // Stores (R7-R9).
        do_req(1'b1, 3'd0, 32'h0020_0000, 16'h0, 32'hDEAD_BEEF, 32'h0);
        do_req(1'b1, 3'd1, 32'h0020_0000, 16'h2, 32'hDEAD_BEEF, 32'h0);
        do_req(1'b1, 3'd4, 32'h0020_0000, 16'h3, 32'hDEAD_BEEF, 32'h0);
        // Misaligned cases (R10).
        do_req(1'b0, 3'd0, 32'h0020_0001, 16'h0, 32'h0, 32'hFFFF_FFFF);
        do_req(1'b1, 3'd2, 32'h0020_0003, 16'h0, 32'h1234_5678, 32'h0);
        idle_check();

        // Random mix.
        for (int i = 0; i < 400; i++) begin
            do_req(1'($urandom), 3'($urandom % 5), $urandom, 16'($urandom),
                   $urandom, $urandom);
            if ($urandom % 8 == 0) idle_check();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule